// File: doc/BRIEF.md
# Optical drive command interface

This block is the byte-wide host front end of an optical-disc drive controller. The host reaches four register offsets through a plain read/write strobe interface. Offset 0 returns a status byte. Offset 1 pops the response queue on a read and issues a command opcode on a write. Offset 2 pops the data queue on a read and pushes a parameter byte on a write. Offset 3 returns the interrupt code together with the interrupt enable mask on a read, and loads the enable mask on a write.

Sector bytes from the drive side enter the data queue through a valid/ready stream. A byte is taken on every rising clock edge where `din_valid` and `din_ready` are both high. `din_ready` drops while the data queue holds its full depth. The producer must then hold its byte until `din_ready` returns, which happens after the host pops.

A small sequencer runs two commands: get-status and a test command with a version subcommand. It answers both with canned bytes, pushed into the response queue one per cycle. When the last byte is pushed it writes a numeric response code into the interrupt flag register. The interrupt line is raised when that code, masked by the enable register, is non-zero.

Top module: `odc_cmd_if`

## Requirements
- R1: After reset the controller is idle, the interrupt code is 0, the enable mask is 0x1F, `irq` is low, offset 0 reads 0x06, offset 3 reads 0x1F, and the drive-status byte is 0x10 (shell-open bit set).
- R2: Status byte at offset 0: bit 1 = parameter queue empty, bit 2 = parameter queue not full, bit 3 = response queue non-empty, bit 4 = data queue non-empty, bit 5 = busy. Each bit reflects a push or pop from the cycle after that edge.
- R3: Status bit 0 (audio-decoder busy) and bits 7:6 always read 0. Bit 5 is 1 in every cycle the sequencer is not idle.
- R4: Each queue holds 16 bytes. A parameter write or a stream byte offered to a full queue is dropped, and the "not full" bit (or `din_ready`) is low while 16 bytes are held.
- R5: Reading offset 1 or offset 2 while that queue is empty returns 0x00 and leaves the queue unchanged.
- R6: Opcode 0x01 (get status) is busy for two cycles after the write edge. On the second edge it pushes the drive-status byte (bit 0 error, 1 motor on, 2 seek error, 3 ID error, 4 shell open, 5 reading, 6 seeking, 7 playing audio) and sets interrupt code 3.
- R7: Opcode 0x19 (test) with parameter head 0x20 is busy for five cycles. It pushes 0x94, 0x09, 0x19, 0xC0 in that order, one byte per cycle. On the last push it empties the parameter queue and sets interrupt code 3.
- R8: A command write made while busy is discarded and has no effect.
- R9: Any other opcode, or a test command whose parameter head is not 0x20 or whose parameter queue is empty, is busy for one cycle and changes no queue or register.
- R10: `irq` is high exactly when (interrupt code AND enable mask) is non-zero. A write to offset 3 loads the mask from bits 4:0.
- R11: A data-queue byte is accepted when `din_valid` and `din_ready` are both high at a clock edge. `din_ready` equals "data queue not full". Offset 2 reads return the data bytes in arrival order.
- R12: Offset 3 reads {code[2:0], mask[4:0]}. The code only ever changes to 3, and it holds its value otherwise.
- R13: While the response queue is full, the sequencer waits in its emit phase and stays busy. It finishes on the cycle after the host frees a slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 2 | Register offset |
| host_rd | input | 1 | Read strobe; pops a queue at offsets 1 and 2 |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for the offset on host_addr |
| din_valid | input | 1 | Drive-side data byte valid |
| din_ready | output | 1 | Data queue can take a byte |
| din_data | input | 8 | Drive-side data byte |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is R13: the sequencer stalling with a response ready while the response queue has no room. The stimulus issues get-status seventeen times without reading offset 1. The last of these stays busy, and a command written during that stall must vanish. Only then does the host drain the queue, one pop releasing the stalled byte. A behavioural model with its own queues predicts status, read data, `irq` and `din_ready` every cycle.

// File: rtl/odc_pkg.sv
package odc_pkg;
  localparam logic [7:0] OP_GET_STATUS = 8'h01;
  localparam logic [7:0] OP_TEST       = 8'h19;
  localparam logic [7:0] SUB_VERSION   = 8'h20;
  localparam logic [2:0] CODE_ACK      = 3'd3;
  localparam logic [4:0] IEN_RESET     = 5'h1F;

  // drive-status byte layout (neighbours decode these bit positions)
  localparam int DS_SHELL_OPEN = 4;

  // main status byte bit positions
  localparam int ST_AUDIO_BUSY = 0;
  localparam int ST_PRM_EMPTY  = 1;
  localparam int ST_PRM_ROOM   = 2;
  localparam int ST_RSP_READY  = 3;
  localparam int ST_DAT_REQ    = 4;
  localparam int ST_BUSY       = 5;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_DECODE, SEQ_EMIT} seq_state_e;

  function automatic logic [7:0] version_byte(input logic [1:0] idx);
    case (idx)
      2'd0:    return 8'h94;
      2'd1:    return 8'h09;
      2'd2:    return 8'h19;
      default: return 8'hC0;
    endcase
  endfunction
endpackage

// File: rtl/odc_fifo.sv
module odc_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  input  logic             clear,
  output logic [W-1:0]     head,
  output logic [CNT_W-1:0] cnt,
  output logic             empty,
  output logic             full
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic             do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CNT_W'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rp];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (clear) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= bump(wp);
      if (do_pop)  rp <= bump(rp);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !clear) mem[wp] <= din;
  end
endmodule

// File: rtl/odc_cmd_seq.sv
module odc_cmd_seq
  import odc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  logic [7:0] cmd_op,
  input  logic       prm_empty,
  input  logic [7:0] prm_head,
  input  logic [7:0] drive_stat,
  input  logic       rsp_full,
  output logic       busy,
  output logic       rsp_push,
  output logic [7:0] rsp_byte,
  output logic       prm_clear,
  output logic       code_set
);
  seq_state_e state;
  logic [7:0] op_q;
  logic [1:0] idx, last_idx;
  logic       is_test, done;

  assign busy      = (state != SEQ_IDLE);
  assign rsp_push  = (state == SEQ_EMIT) && !rsp_full;
  assign rsp_byte  = is_test ? version_byte(idx) : drive_stat;
  assign done      = rsp_push && (idx == last_idx);
  assign prm_clear = done && is_test;
  assign code_set  = done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SEQ_IDLE;
      op_q     <= '0;
      idx      <= '0;
      last_idx <= '0;
      is_test  <= 1'b0;
    end else begin
      case (state)
        SEQ_IDLE: if (cmd_wr) begin
          op_q  <= cmd_op;
          state <= SEQ_DECODE;
        end
        SEQ_DECODE: begin
          idx <= '0;
          if (op_q == OP_GET_STATUS) begin
            is_test  <= 1'b0;
            last_idx <= 2'd0;
            state    <= SEQ_EMIT;
          end else if (op_q == OP_TEST && !prm_empty && prm_head == SUB_VERSION) begin
            is_test  <= 1'b1;
            last_idx <= 2'd3;
            state    <= SEQ_EMIT;
          end else begin
            state <= SEQ_IDLE;
          end
        end
        SEQ_EMIT: if (rsp_push) begin
          idx <= idx + 1'b1;
          if (done) state <= SEQ_IDLE;
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/odc_cmd_if.sv
module odc_cmd_if
  import odc_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] host_addr,
  input  logic       host_rd,
  input  logic       host_wr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  input  logic       din_valid,
  output logic       din_ready,
  input  logic [7:0] din_data,
  output logic       irq
);
  logic [7:0]       drive_stat_q;
  logic [2:0]       code_q;
  logic [4:0]       ien_q;
  logic             busy, rsp_push, prm_clear, code_set;
  logic [7:0]       rsp_byte, rsp_head, prm_head, dat_head, status;
  logic [CNT_W-1:0] rsp_cnt, prm_cnt, dat_cnt;
  logic             rsp_empty, rsp_full, prm_empty, prm_full, dat_empty, dat_full;

  wire sel1 = (host_addr == 2'd1);
  wire sel2 = (host_addr == 2'd2);
  wire sel3 = (host_addr == 2'd3);

  odc_fifo #(.W(8), .DEPTH(DEPTH)) u_rsp (
    .clk(clk), .rst_n(rst_n), .push(rsp_push), .din(rsp_byte),
    .pop(host_rd && sel1), .clear(1'b0), .head(rsp_head), .cnt(rsp_cnt),
    .empty(rsp_empty), .full(rsp_full));

  odc_fifo #(.W(8), .DEPTH(DEPTH)) u_prm (
    .clk(clk), .rst_n(rst_n), .push(host_wr && sel2), .din(host_wdata),
    .pop(1'b0), .clear(prm_clear), .head(prm_head), .cnt(prm_cnt),
    .empty(prm_empty), .full(prm_full));

  odc_fifo #(.W(8), .DEPTH(DEPTH)) u_dat (
    .clk(clk), .rst_n(rst_n), .push(din_valid), .din(din_data),
    .pop(host_rd && sel2), .clear(1'b0), .head(dat_head), .cnt(dat_cnt),
    .empty(dat_empty), .full(dat_full));

  odc_cmd_seq u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_wr(host_wr && sel1), .cmd_op(host_wdata),
    .prm_empty(prm_empty), .prm_head(prm_head), .drive_stat(drive_stat_q),
    .rsp_full(rsp_full), .busy(busy), .rsp_push(rsp_push), .rsp_byte(rsp_byte),
    .prm_clear(prm_clear), .code_set(code_set));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive_stat_q <= 8'(1 << DS_SHELL_OPEN);
      code_q       <= '0;
      ien_q        <= IEN_RESET;
    end else begin
      drive_stat_q <= drive_stat_q;
      if (code_set) code_q <= CODE_ACK;
      if (host_wr && sel3) ien_q <= host_wdata[4:0];
    end
  end

  always_comb begin
    status                = '0;
    status[ST_AUDIO_BUSY] = 1'b0;
    status[ST_PRM_EMPTY]  = prm_empty;
    status[ST_PRM_ROOM]   = !prm_full;
    status[ST_RSP_READY]  = !rsp_empty;
    status[ST_DAT_REQ]    = !dat_empty;
    status[ST_BUSY]       = busy;
  end

  always_comb begin
    case (host_addr)
      2'd0:    host_rdata = status;
      2'd1:    host_rdata = rsp_empty ? 8'h00 : rsp_head;
      2'd2:    host_rdata = dat_empty ? 8'h00 : dat_head;
      default: host_rdata = {code_q, ien_q};
    endcase
  end

  assign din_ready = !dat_full;
  assign irq       = |({2'b00, code_q} & ien_q);

  logic unused_ok;
  assign unused_ok = ^dat_cnt;
endmodule

// File: rtl/odc_cmd_if_chk.sv
module odc_cmd_if_chk #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       host_addr,
  input logic             host_wr,
  input logic [7:0]       host_rdata,
  input logic             irq,
  input logic             busy,
  input logic             rsp_push,
  input logic [2:0]       code_q,
  input logic [CNT_W-1:0] rsp_cnt,
  input logic [CNT_W-1:0] prm_cnt
);
  assert_status_zero_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr == 2'd0) |-> (host_rdata[0] == 1'b0 && host_rdata[7:6] == 2'b00));

  assert_irq_vs_fields_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr == 2'd3) |-> (irq == (({2'b00, host_rdata[7:5]} & host_rdata[4:0]) != 5'd0)));

  assert_busy_from_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(host_wr && host_addr == 2'd1));

  assert_depth_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_cnt <= CNT_W'(DEPTH)) && (prm_cnt <= CNT_W'(DEPTH)));

  assert_empty_pop_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_cnt == '0 && !rsp_push) |=> (rsp_cnt == '0));

  assert_code_only_ack_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code_q) |-> (code_q == 3'd3));
endmodule

bind odc_cmd_if odc_cmd_if_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
  .host_rdata(host_rdata), .irq(irq), .busy(busy), .rsp_push(rsp_push),
  .code_q(code_q), .rsp_cnt(rsp_cnt), .prm_cnt(prm_cnt));

// File: tb/sim_odc_cmd_if.sv
`timescale 1ns/1ps
module sim_odc_cmd_if;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] host_addr = '0;
  logic       host_rd = 1'b0, host_wr = 1'b0, din_valid = 1'b0;
  logic [7:0] host_wdata = '0, din_data = '0;
  logic [7:0] host_rdata;
  logic       din_ready, irq;

  int vectors = 0, miscompares = 0;
  bit finished = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  odc_cmd_if u0 (.clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .din_valid(din_valid), .din_ready(din_ready), .din_data(din_data), .irq(irq));

  // behavioural reference
  byte unsigned rq[$], pq[$], dq[$], outq[$];
  int phase = 0;
  byte unsigned op = 0, flag = 0, ien = 8'h1F;
  bit tst = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      rq.delete(); pq.delete(); dq.delete(); outq.delete();
      phase = 0; flag = 0; ien = 8'h1F; tst = 0;
    end else begin
      int rqn, pqn, dqn;
      bit clr, pr;
      byte unsigned pb;
      rqn = rq.size(); pqn = pq.size(); dqn = dq.size();
      clr = 0; pr = 0; pb = 0;
      case (phase)
        0: if (host_wr && host_addr == 1) begin op = host_wdata; phase = 1; end
        1: begin
          if (op == 8'h01) begin outq = '{8'h10}; tst = 0; phase = 2; end
          else if (op == 8'h19 && pqn != 0 && pq[0] == 8'h20) begin
            outq = '{8'h94, 8'h09, 8'h19, 8'hC0}; tst = 1; phase = 2;
          end else phase = 0;
        end
        default: if (rqn < 16) begin
          pr = 1; pb = outq.pop_front();
          if (outq.size() == 0) begin flag = 3; clr = tst; phase = 0; end
        end
      endcase
      if (host_rd && host_addr == 1 && rqn != 0) void'(rq.pop_front());
      if (pr) rq.push_back(pb);
      if (host_wr && host_addr == 2 && pqn < 16) pq.push_back(host_wdata);
      if (clr) pq.delete();
      if (host_rd && host_addr == 2 && dqn != 0) void'(dq.pop_front());
      if (din_valid && dqn < 16) dq.push_back(din_data);
      if (host_wr && host_addr == 3) ien = {3'b000, host_wdata[4:0]};
    end
  end

  function automatic logic [7:0] exp_rdata();
    case (host_addr)
      2'd0: return {2'b00, phase != 0, dq.size() != 0, rq.size() != 0,
                    pq.size() < 16, pq.size() == 0, 1'b0};
      2'd1: return rq.size() != 0 ? rq[0] : 8'h00;
      2'd2: return dq.size() != 0 ? dq[0] : 8'h00;
      default: return {flag[2:0], ien[4:0]};
    endcase
  endfunction

  task automatic cmp(input logic [7:0] got, input logic [7:0] exp, input string req);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s (%s) addr=%0d actual=%h expected=%h at %0t",
               req, cur_req, host_addr, got, exp, $time);
    end
  endtask

  task automatic check_all();
    string rtag;
    case (host_addr)
      2'd0: rtag = "R2";
      2'd1: rtag = "R6";
      2'd2: rtag = "R11";
      default: rtag = "R12";
    endcase
    cmp(host_rdata, exp_rdata(), rtag);
    cmp({7'd0, irq}, {7'd0, (flag[4:0] & ien[4:0]) != 0}, "R10");
    cmp({7'd0, din_ready}, {7'd0, dq.size() < 16}, "R11");
  endtask

  task automatic step(input logic r, input logic w, input logic [1:0] a,
                      input logic [7:0] d, input logic dv, input logic [7:0] dd);
    @(negedge clk);
    host_rd = r; host_wr = w; host_addr = a; host_wdata = d;
    din_valid = dv; din_data = dd;
    #2 check_all();
  endtask

  task automatic idle(input logic [1:0] a, input int n);
    for (int i = 0; i < n; i++) step(0, 0, a, 8'h00, 0, 8'h00);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values
    cur_req = "R1";
    idle(0, 1); cmp(host_rdata, 8'h06, "R1");
    idle(3, 1); cmp(host_rdata, 8'h1F, "R1");
    // R5: empty pops
    cur_req = "R5";
    step(1, 0, 1, 0, 0, 0); cmp(host_rdata, 8'h00, "R5");
    step(1, 0, 2, 0, 0, 0); cmp(host_rdata, 8'h00, "R5");
    idle(0, 1); cmp(host_rdata, 8'h06, "R5");
    // R6 / R3: get status
    cur_req = "R6";
    step(0, 1, 1, 8'h01, 0, 0);
    cur_req = "R3";
    idle(0, 1); cmp(host_rdata[5], 1'b1, "R3");
    idle(0, 2);
    cur_req = "R6";
    idle(1, 1); cmp(host_rdata, 8'h10, "R6");
    step(1, 0, 1, 0, 0, 0);
    idle(3, 1); cmp(host_rdata, 8'h7F, "R12");
    // R10: masking
    cur_req = "R10";
    step(0, 1, 3, 8'h00, 0, 0); idle(3, 1); cmp({7'd0, irq}, 8'd0, "R10");
    step(0, 1, 3, 8'h04, 0, 0); idle(3, 1); cmp({7'd0, irq}, 8'd0, "R10");
    step(0, 1, 3, 8'h02, 0, 0); idle(3, 1); cmp({7'd0, irq}, 8'd1, "R10");
    step(0, 1, 3, 8'hFF, 0, 0); idle(0, 1);
    // R7 / R8: version test, extra command while busy
    cur_req = "R7";
    step(0, 1, 2, 8'h20, 0, 0);
    step(0, 1, 2, 8'h55, 0, 0);
    step(0, 1, 1, 8'h19, 0, 0);
    cur_req = "R8";
    step(0, 1, 1, 8'h01, 0, 0);
    idle(0, 5);
    cur_req = "R7";
    for (int i = 0; i < 5; i++) step(1, 0, 1, 0, 0, 0);
    idle(0, 2); cmp(host_rdata, 8'h06, "R7");
    // R9: unknown opcode, unknown subcommand, empty-parameter test
    cur_req = "R9";
    step(0, 1, 1, 8'h05, 0, 0); idle(0, 3);
    step(0, 1, 1, 8'h19, 0, 0); idle(0, 3);
    step(0, 1, 2, 8'h33, 0, 0);
    step(0, 1, 1, 8'h19, 0, 0); idle(0, 3);
    // R4: fill parameter queue past depth
    cur_req = "R4";
    for (int i = 0; i < 17; i++) step(0, 1, 2, 8'(i), 0, 0);
    idle(0, 1); cmp(host_rdata[2], 1'b0, "R4");
    step(0, 1, 1, 8'h19, 0, 0); idle(0, 3);
    // R11: data stream fill and drain
    cur_req = "R11";
    for (int i = 0; i < 18; i++) step(0, 0, 0, 0, 1, 8'(8'hA0 + i));
    idle(0, 1); cmp({7'd0, din_ready}, 8'd0, "R11");
    for (int i = 0; i < 17; i++) step(1, 0, 2, 0, 0, 0);
    step(1, 0, 2, 0, 1, 8'h5A);
    idle(2, 2);
    // R13: response queue full stall
    cur_req = "R13";
    for (int i = 0; i < 17; i++) begin
      step(0, 1, 1, 8'h01, 0, 0);
      idle(0, 2);
    end
    idle(0, 3); cmp(host_rdata[5], 1'b1, "R13");
    cur_req = "R8";
    step(0, 1, 1, 8'h05, 0, 0); idle(0, 2);
    cur_req = "R13";
    for (int i = 0; i < 18; i++) step(1, 0, 1, 0, 0, 0);
    idle(0, 3);
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule